// File: doc/BRIEF.md
# SMM Memory Window Access Controller

This block owns the 8-bit control register that guards the system-management memory window. It also decides, for every memory access, whether the access is claimed by local memory or passed to the downstream hub. The window is fixed at A0000h to BFFFFh (128 KB). Whether an access lands there depends on four things: the global enable, the SMM-mode flag of the access, whether the access is a code fetch or a data reference, and the open and close control bits.

Firmware uses the open bit to reach the window from outside SMM while it sets the window up. It then sets the lock bit. The lock bit clears open and freezes lock, open and global enable until the next full reset. Close stays writable after lock, so SMM code can still let data references fall through to the downstream path while its own code fetches keep hitting local memory.

The route decision and the register read-back are both registered. Each one appears on the clock edge after the access or read is presented. Both are computed from the register state as it was before any write made in that same cycle.

Top module: `smm_window_ctrl`

## Requirements
- R1: A full reset (`rst` high at a clock edge) clears open, close, lock and global enable. A read made after reset returns 02h, and the route outputs are 0 on the edge after reset.
- R2: When `cfg_rd` is high at an edge, `cfg_rdata` holds the register value from the next edge on. The layout is: bit 7 = 0, bit 6 = open, bit 5 = close, bit 4 = lock, bit 3 = global enable, bits 2:0 = base segment. When `cfg_rd` is low, `cfg_rdata` is 00h.
- R3: The base segment always reads 010, and bit 7 always reads 0. Write data in bits 7 and 2:0 has no effect.
- R4: While global enable is 0, every access is forwarded (`route_local` = 0).
- R5: An access with an address below A0000h or above BFFFFh is always forwarded. A0000h and BFFFFh are both inside the window.
- R6: With global enable 1 and close 0, an SMM-mode access inside the window is claimed, whether it is code (`acc_code` = 1) or data (`acc_code` = 0).
- R7: With global enable 1 and close 1, an SMM-mode data access inside the window is forwarded, while an SMM-mode code fetch is claimed.
- R8: With global enable 1, a non-SMM access inside the window is claimed only when open is 1 and lock is 0. Otherwise it is forwarded.
- R9: A write with bit 4 set stores lock = 1 and open = 0, even when the same write also sets bit 6.
- R10: While lock is 1, writes leave lock, open and global enable unchanged, but close still follows bit 5 of the write data.
- R11: Once set, lock stays 1 through any writes. Only a full reset clears it.
- R12: Open and close may both be 1. In that state an SMM-mode data access is forwarded and a non-SMM access is claimed.
- R13: `route_valid` is `acc_valid` delayed by one edge. `route_local` is 0 whenever `route_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Full reset, synchronous, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Registered read-back data |
| acc_valid | input | 1 | Memory access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_smm | input | 1 | Access issued in SMM mode |
| acc_code | input | 1 | Access is a code fetch (1) or a data reference (0) |
| route_valid | output | 1 | Registered decision is valid |
| route_local | output | 1 | 1 = claimed by local window memory, 0 = forwarded downstream |

## Verification
The bench drives the lock write that also sets open. A design that orders the open clear wrongly would leave open set and keep admitting non-SMM accesses after lock. It probes the window edges 9FFFFh, A0000h, BFFFFh and C0000h, where an off-by-one compare would claim a forwarded address or drop a valid one. With close set, it checks that SMM data and SMM code take different routes; a design that ignores the code/data qualifier sends both the same way. It also tries to clear lock, open and global enable by writing after lock, and checks that close still changes, which catches a freeze applied to the wrong bits.

// File: rtl/smm_pkg.sv
package smm_pkg;

  localparam int REG_W     = 8;
  localparam int OPEN_POS  = 6;
  localparam int CLOSE_POS = 5;
  localparam int LOCK_POS  = 4;
  localparam int GEN_POS   = 3;
  localparam int SEG_W     = 3;
  localparam logic [SEG_W-1:0] BASE_SEG = 3'b010;

  typedef struct packed {
    logic open;
    logic cls;
    logic lck;
    logic gen;
  } smm_ctl_t;

  function automatic logic [REG_W-1:0] pack_ctl(input smm_ctl_t c);
    logic [REG_W-1:0] v;
    v = '0;
    v[OPEN_POS]    = c.open;
    v[CLOSE_POS]   = c.cls;
    v[LOCK_POS]    = c.lck;
    v[GEN_POS]     = c.gen;
    v[SEG_W-1:0]   = BASE_SEG;
    return v;
  endfunction

endpackage

// File: rtl/smm_ctrl_reg.sv
module smm_ctrl_reg
  import smm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  output smm_ctl_t         ctl,
  output logic [REG_W-1:0] rdata
);

  smm_ctl_t ctl_q;
  smm_ctl_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr) begin
      ctl_d.cls = wdata[CLOSE_POS];
      if (!ctl_q.lck) begin
        ctl_d.gen  = wdata[GEN_POS];
        ctl_d.lck  = wdata[LOCK_POS];
        ctl_d.open = wdata[OPEN_POS] & ~wdata[LOCK_POS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      rdata <= '0;
    end else begin
      ctl_q <= ctl_d;
      rdata <= rd ? pack_ctl(ctl_q) : '0;
    end
  end

  assign ctl = ctl_q;

  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q.lck |=> ctl_q.lck);

  // R9
  open_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q.lck |-> !ctl_q.open);

  // R10
  gen_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q.lck |=> $stable(ctl_q.gen));

  // R3
  seg_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> (rdata[REG_W-1] == 1'b0 && rdata[SEG_W-1:0] == BASE_SEG));

endmodule

// File: rtl/smm_addr_match.sv
module smm_addr_match #(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_win
);

  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1'b1;
  localparam bit ALIGNED_POW2 =
    ((WIN_SIZE & (WIN_SIZE - 1'b1)) == '0) && ((WIN_BASE & (WIN_SIZE - 1'b1)) == '0);
  localparam int SZ_LG = $clog2(WIN_SIZE);

  generate
    if (ALIGNED_POW2 && SZ_LG > 0 && SZ_LG < ADDR_W) begin : g_mask
      assign in_win = (addr[ADDR_W-1:SZ_LG] == WIN_BASE[ADDR_W-1:SZ_LG]);
    end else begin : g_range
      assign in_win = (addr >= WIN_BASE) && (addr <= WIN_LAST);
    end
  endgenerate

endmodule

// File: rtl/smm_route.sv
module smm_route
  import smm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     acc_valid,
  input  logic     in_win,
  input  logic     acc_smm,
  input  logic     acc_code,
  input  smm_ctl_t ctl,
  output logic     route_valid,
  output logic     route_local
);

  logic smm_ok;
  logic open_ok;
  logic claim;

  always_comb begin
    smm_ok  = acc_smm & (acc_code | ~ctl.cls);
    open_ok = ~acc_smm & ctl.open & ~ctl.lck;
    claim   = acc_valid & in_win & ctl.gen & (smm_ok | open_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_valid <= 1'b0;
      route_local <= 1'b0;
    end else begin
      route_valid <= acc_valid;
      route_local <= claim;
    end
  end

  // R13
  idle_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (!route_valid && !route_local));

  // R5
  outside_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !in_win) |=> (route_valid && !route_local));

endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl
  import smm_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h000A_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  input  logic              acc_code,
  output logic              route_valid,
  output logic              route_local
);

  smm_ctl_t ctl;
  logic     in_win;

  smm_ctrl_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .rd    (cfg_rd),
    .wdata (cfg_wdata),
    .ctl   (ctl),
    .rdata (cfg_rdata)
  );

  smm_addr_match #(
    .ADDR_W   (ADDR_W),
    .WIN_BASE (WIN_BASE),
    .WIN_SIZE (WIN_SIZE)
  ) u_match (
    .addr   (acc_addr),
    .in_win (in_win)
  );

  smm_route u_route (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .in_win      (in_win),
    .acc_smm     (acc_smm),
    .acc_code    (acc_code),
    .ctl         (ctl),
    .route_valid (route_valid),
    .route_local (route_local)
  );

  // R4
  gen_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.gen |=> !route_local);

  // R7
  close_data_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ctl.gen && ctl.cls && acc_smm && !acc_code) |=> !route_local);

  // R8
  locked_nonsmm_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && ctl.lck && !acc_smm) |=> !route_local);

endmodule

// File: tb/smm_window_ctrl_test.sv
module smm_window_ctrl_test;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          acc_valid = 1'b0, acc_smm = 1'b0, acc_code = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic          route_valid, route_local;

  int checks = 0;
  int failures = 0;

  // behavioural model state
  bit m_open, m_cls, m_lck, m_gen;

  always #4 clk = ~clk;

  smm_window_ctrl uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_smm(acc_smm),
    .acc_code(acc_code), .route_valid(route_valid), .route_local(route_local)
  );

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, model the edge, compare at the next negedge.
  task automatic step(input string req, input bit r, input bit wr, input bit rd,
                      input int wd, input bit v, input int addr, input bit smm,
                      input bit code);
    int  e_rd;
    bit  e_rv, e_rl, inw;
    rst = r; cfg_wr = wr; cfg_rd = rd; cfg_wdata = wd[7:0];
    acc_valid = v; acc_addr = addr; acc_smm = smm; acc_code = code;
    inw = (addr >= 32'hA0000) && (addr <= 32'hBFFFF);
    if (r) begin
      e_rd = 0; e_rv = 0; e_rl = 0;
      m_open = 0; m_cls = 0; m_lck = 0; m_gen = 0;
    end else begin
      e_rd = rd ? ((m_open << 6) | (m_cls << 5) | (m_lck << 4) | (m_gen << 3) | 2) : 0;
      e_rv = v;
      e_rl = 0;
      if (v && inw && m_gen) begin
        if (smm) e_rl = code || !m_cls;
        else     e_rl = m_open && !m_lck;
      end
      if (wr) begin
        m_cls = wd[5];
        if (!m_lck) begin
          m_gen  = wd[3];
          m_lck  = wd[4];
          m_open = wd[6] && !wd[4];
        end
      end
    end
    @(negedge clk);
    cmp(req, "cfg_rdata", cfg_rdata, e_rd);
    cmp(req, "route_valid", route_valid, e_rv);
    cmp(req, "route_local", route_local, e_rl);
  endtask

  task automatic wr_reg(input string req, input int d);
    step(req, 0, 1, 0, d, 0, 0, 0, 0);
  endtask
  task automatic rd_reg(input string req);
    step(req, 0, 0, 1, 0, 0, 0, 0, 0);
  endtask
  task automatic acc(input string req, input int a, input bit smm, input bit code);
    step(req, 0, 0, 0, 0, 1, a, smm, code);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin : main
    @(negedge clk);
    // R1 reset state
    step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 0, 0, 0, 1, 32'hA0000, 1, 1);
    rd_reg("R1");
    rd_reg("R2");
    // R4 global enable off
    acc("R4", 32'hA0000, 1, 1);
    acc("R4", 32'hB0000, 1, 0);
    acc("R4", 32'hB0000, 0, 0);
    // R3 reserved and base-segment writes ignored
    wr_reg("R3", 8'hC7);
    rd_reg("R3");
    wr_reg("R3", 8'h8D);
    rd_reg("R3");
    // R6 SMM code and data claimed
    wr_reg("R6", 8'h08);
    acc("R6", 32'hA8000, 1, 1);
    acc("R6", 32'hA8000, 1, 0);
    // R5 boundaries
    acc("R5", 32'h9FFFF, 1, 0);
    acc("R5", 32'hA0000, 1, 0);
    acc("R5", 32'hBFFFF, 1, 0);
    acc("R5", 32'hC0000, 1, 1);
    acc("R5", 32'h100A0000, 1, 1);
    // R13 invalid access
    step("R13", 0, 0, 0, 0, 0, 32'hA0000, 1, 1);
    // R8 non-SMM without open
    acc("R8", 32'hA0000, 0, 0);
    // R7 close
    wr_reg("R7", 8'h28);
    acc("R7", 32'hA4000, 1, 0);
    acc("R7", 32'hA4000, 1, 1);
    acc("R7", 32'hA4000, 0, 0);
    // R12 open and close together
    wr_reg("R12", 8'h68);
    rd_reg("R12");
    acc("R12", 32'hB8000, 1, 0);
    acc("R12", 32'hB8000, 0, 0);
    acc("R12", 32'hB8000, 1, 1);
    // R8 open admits non-SMM
    wr_reg("R8", 8'h48);
    acc("R8", 32'hB0000, 0, 1);
    acc("R8", 32'hC0000, 0, 1);
    // R9 lock with open in same write
    wr_reg("R9", 8'h58);
    rd_reg("R9");
    acc("R9", 32'hB0000, 0, 0);
    // R10 frozen fields, close writable
    wr_reg("R10", 8'h40);
    rd_reg("R10");
    wr_reg("R10", 8'h20);
    rd_reg("R10");
    acc("R10", 32'hA0000, 1, 0);
    acc("R10", 32'hA0000, 1, 1);
    // R11 lock survives writes, cleared by reset
    wr_reg("R11", 8'h00);
    rd_reg("R11");
    step("R11", 1, 0, 0, 0, 0, 0, 0, 0);
    rd_reg("R11");
    // mixed traffic, compared every clock, with periodic resets
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom;
      step("R6", (i % 700) == 699, (r & 15) == 0, r[4], $urandom & 8'hFF,
           r[5], 32'h9F000 + ($urandom % 32'h23000), r[6], r[7]);
    end
    report();
    $finish;
  end

endmodule